// File: doc/BRIEF.md
# SIMD Float Status Register

This block holds the floating-point status and control state of a four-lane SIMD arithmetic unit. The state is 128 bits wide and is arranged as four 32-bit words. Word 0 is the least-significant word. The words hold three kinds of sticky exception flag: flags for each of four single-precision slices, flags for each of two double-precision slices, and four divide-by-zero flags. Word 3 also holds a 2-bit rounding-mode field for each double-precision slice.

Software can replace the whole register with a masked 128-bit write, and the full contents are always visible on a read port. The arithmetic lanes report exceptions through per-slice strobes. Each strobe ORs bits into a fixed word and bit position. A separate narrow port writes and reads one rounding-mode field, selected by a slice index. Reset is synchronous and active high, and it clears every bit. This block does not produce the exceptions; it only records them.

Top module: `vfp_status_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 128 bits of the register become zero, and any write or strobe in that cycle is discarded.
- R2: A full write (`wr_en`) stores each word of `wr_data` ANDed with its implemented-bit mask. The masks are 0x00000F07 for word 0, 0x00003F07 for word 1, 0x00003F07 for word 2 and 0x00000F07 for word 3. Word n is `wr_data[32n+31:32n]`.
- R3: `rd_data` always shows the current register contents, with word n on bits 32n+31:32n. Word 0 is the least-significant word.
- R4: For single-precision slice n (0 to 3), `sp_set[3n+2]` sets overflow at bit 2 of word n, `sp_set[3n+1]` sets underflow at bit 1, and `sp_set[3n]` sets the "different" flag at bit 0.
- R5: For double-precision slice n (0 or 1), `dp_set[6n+5:6n]` sets, in order, overflow, underflow, inexact, invalid, NaN and denormal. These land at bits 13, 12, 11, 10, 9 and 8 of word 1+n.
- R6: `dz_set[n]` sets the divide-by-zero flag of slice n at bit 8+n of word 0.
- R7: Strobes only add bits and never clear them. A flag stays set through any number of idle cycles, until a full write or a reset changes it.
- R8: When a full write and strobes arrive in the same cycle, the write is applied first and the strobe bits are ORed on top of it.
- R9: A rounding write (`rm_wr_en`) with slice 0 puts `rm_wr_val` into word 3 bits 9:8, and with slice 1 into word 3 bits 11:10. No other bit changes. If a full write occurs in the same cycle, the rounding write overrides that field of the written value.
- R10: `rm_rd_val` shows, in the same cycle, the rounding field selected by `rm_rd_slice`: bits 9:8 of word 3 for slice 0 and bits 11:10 for slice 1.
- R11: A rounding write with slice index 2 or 3 changes nothing, and a rounding read with slice index 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full masked write strobe |
| wr_data | input | 128 | Full write value, word 0 in the low 32 bits |
| rd_data | output | 128 | Current register contents |
| sp_set | input | 12 | Single-precision flag strobes, 3 per slice |
| dp_set | input | 12 | Double-precision flag strobes, 6 per slice |
| dz_set | input | 4 | Divide-by-zero strobes, one per slice |
| rm_wr_en | input | 1 | Rounding-mode write strobe |
| rm_wr_slice | input | 2 | Slice index for the rounding write |
| rm_wr_val | input | 2 | Rounding mode value to write |
| rm_rd_slice | input | 2 | Slice index for the rounding read |
| rm_rd_val | output | 2 | Selected rounding mode, 0 when the index is out of range |

## Verification
Full writes are tried with all-ones and with a set of arithmetic scramble patterns. These show whether each word has the correct implemented-bit mask and whether word order is correct. The single-precision, double-precision and divide-by-zero strobes are swept over every non-zero flag combination in every slice, starting from a cleared register. This separates a flag that lands in the wrong bit from one that lands in the wrong word. Further sequences cover the corner cases:
- strobes repeated across idle cycles, which separate sticky flags from flags that are overwritten;
- a write and strobes in the same cycle, which shows which one is applied first;
- every rounding value written to every slice index, including the two out-of-range indices.

// File: rtl/vfp_status_pkg.sv
package vfp_status_pkg;

    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = 4;
    localparam int SP_LANES    = 4;
    localparam int DP_LANES    = 2;
    localparam int SP_FLAG_W   = 3;
    localparam int DP_FLAG_W   = 6;
    localparam int RM_W        = 2;
    localparam int SLICE_IDX_W = 2;

    localparam int REG_W       = WORD_W * NUM_WORDS;
    localparam int SP_SET_W    = SP_LANES * SP_FLAG_W;
    localparam int DP_SET_W    = DP_LANES * DP_FLAG_W;
    localparam int RM_FIELD_W  = DP_LANES * RM_W;

    // bit placement inside a word
    localparam int DP_FLAG_LSB = 8;
    localparam int DZ_LSB      = 8;
    localparam int RM_LSB      = 8;
    localparam int RM_WORD     = NUM_WORDS - 1;
    localparam int DP_WORD0    = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] fpsr_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic diff;
    } sp_flags_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
        logic inv;
        logic nan;
        logic den;
    } dp_flags_t;

    // implemented bits of each word
    function automatic word_t word_mask(int idx);
        if (idx >= DP_WORD0 && idx < DP_WORD0 + DP_LANES)
            return word_t'(32'h0000_3F07);
        return word_t'(32'h0000_0F07);
    endfunction

    function automatic word_t sp_bits(sp_flags_t f);
        word_t w;
        w    = '0;
        w[2] = f.ovf;
        w[1] = f.unf;
        w[0] = f.diff;
        return w;
    endfunction

    function automatic word_t dp_bits(dp_flags_t f);
        word_t w;
        w = '0;
        w[DP_FLAG_LSB +: DP_FLAG_W] = f;
        return w;
    endfunction

endpackage

// File: rtl/vfp_set_decode.sv
module vfp_set_decode
    import vfp_status_pkg::*;
(
    input  logic [SP_SET_W-1:0] sp_set,
    input  logic [DP_SET_W-1:0] dp_set,
    input  logic [SP_LANES-1:0] dz_set,
    output fpsr_t               set_bits
);

    fpsr_t sp_part;
    fpsr_t dp_part;
    fpsr_t dz_part;

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            // each single-precision slice owns the word of the same index
            if (w < SP_LANES) begin : g_sp
                assign sp_part[w] = sp_bits(sp_flags_t'(sp_set[w*SP_FLAG_W +: SP_FLAG_W]));
            end else begin : g_no_sp
                assign sp_part[w] = '0;
            end

            if (w >= DP_WORD0 && w < DP_WORD0 + DP_LANES) begin : g_dp
                assign dp_part[w] = dp_bits(dp_flags_t'(dp_set[(w-DP_WORD0)*DP_FLAG_W +: DP_FLAG_W]));
            end else begin : g_no_dp
                assign dp_part[w] = '0;
            end

            if (w == 0) begin : g_dz
                assign dz_part[w] = {{(WORD_W-SP_LANES){1'b0}}, dz_set} << DZ_LSB;
            end else begin : g_no_dz
                assign dz_part[w] = '0;
            end
        end
    endgenerate

    assign set_bits = sp_part | dp_part | dz_part;

endmodule

// File: rtl/vfp_round_port.sv
module vfp_round_port
    import vfp_status_pkg::*;
(
    input  logic [RM_FIELD_W-1:0]  rm_field,
    input  logic                   wr_en,
    input  logic [SLICE_IDX_W-1:0] wr_slice,
    input  logic [RM_W-1:0]        wr_val,
    input  logic [SLICE_IDX_W-1:0] rd_slice,
    output word_t                  clr_mask,
    output word_t                  ins_bits,
    output logic [RM_W-1:0]        rd_val
);

    logic wr_in_range;
    logic rd_in_range;

    assign wr_in_range = int'(wr_slice) < DP_LANES;
    assign rd_in_range = int'(rd_slice) < DP_LANES;

    always_comb begin
        clr_mask = '0;
        ins_bits = '0;
        if (wr_en && wr_in_range) begin
            clr_mask[RM_LSB + RM_W*int'(wr_slice) +: RM_W] = '1;
            ins_bits[RM_LSB + RM_W*int'(wr_slice) +: RM_W] = wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_in_range)
            rd_val = rm_field[RM_W*int'(rd_slice) +: RM_W];
    end

endmodule

// File: rtl/vfp_word_cell.sv
module vfp_word_cell
    import vfp_status_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_word,
    input  word_t clr_mask,
    input  word_t ins_bits,
    input  word_t set_bits,
    output word_t q
);

    localparam word_t MASK = word_mask(IDX);

    word_t base;
    word_t nxt;

    // order: masked write, then field insert, then sticky OR
    always_comb begin
        base = wr_en ? (wr_word & MASK) : q;
        nxt  = ((base & ~clr_mask) | ins_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> q == '0); // R1

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (q & ~MASK) == '0); // R2

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en && set_bits == '0 && clr_mask == '0 |=> q == $past(wr_word & MASK)); // R2

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($past(q) & ~$past(clr_mask) & ~q) == '0); // R7

    AST_SET_ON_TOP: assert property (@(posedge clk) disable iff (rst)
        set_bits != '0 |=> (q & $past(set_bits)) == $past(set_bits)); // R8

endmodule

// File: rtl/vfp_status_reg.sv
module vfp_status_reg
    import vfp_status_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    input  logic [SP_SET_W-1:0]    sp_set,
    input  logic [DP_SET_W-1:0]    dp_set,
    input  logic [SP_LANES-1:0]    dz_set,
    input  logic                   rm_wr_en,
    input  logic [SLICE_IDX_W-1:0] rm_wr_slice,
    input  logic [RM_W-1:0]        rm_wr_val,
    input  logic [SLICE_IDX_W-1:0] rm_rd_slice,
    output logic [RM_W-1:0]        rm_rd_val
);

    fpsr_t regs;
    fpsr_t set_bits;
    fpsr_t wr_words;
    word_t rm_clr;
    word_t rm_ins;

    assign wr_words = fpsr_t'(wr_data);
    assign rd_data  = REG_W'(regs);

    vfp_set_decode u_decode (
        .sp_set   (sp_set),
        .dp_set   (dp_set),
        .dz_set   (dz_set),
        .set_bits (set_bits)
    );

    vfp_round_port u_round (
        .rm_field (regs[RM_WORD][RM_LSB +: RM_FIELD_W]),
        .wr_en    (rm_wr_en),
        .wr_slice (rm_wr_slice),
        .wr_val   (rm_wr_val),
        .rd_slice (rm_rd_slice),
        .clr_mask (rm_clr),
        .ins_bits (rm_ins),
        .rd_val   (rm_rd_val)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_cell
            word_t cell_clr;
            word_t cell_ins;
            if (w == RM_WORD) begin : g_rm
                assign cell_clr = rm_clr;
                assign cell_ins = rm_ins;
            end else begin : g_plain
                assign cell_clr = '0;
                assign cell_ins = '0;
            end

            vfp_word_cell #(.IDX(w)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_en),
                .wr_word  (wr_words[w]),
                .clr_mask (cell_clr),
                .ins_bits (cell_ins),
                .set_bits (set_bits[w]),
                .q        (regs[w])
            );
        end
    endgenerate

    AST_RM_SLICE0: assert property (@(posedge clk) disable iff (rst)
        rm_wr_en && rm_wr_slice == 2'd0 |=>
        regs[RM_WORD][RM_LSB +: RM_W] == $past(rm_wr_val)); // R9

    AST_RM_SLICE1: assert property (@(posedge clk) disable iff (rst)
        rm_wr_en && rm_wr_slice == 2'd1 |=>
        regs[RM_WORD][RM_LSB+RM_W +: RM_W] == $past(rm_wr_val)); // R9

    AST_RM_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        rm_wr_en && int'(rm_wr_slice) >= DP_LANES && !wr_en |=>
        $stable(regs[RM_WORD][RM_LSB +: RM_FIELD_W])); // R11

endmodule

// File: tb/vfp_status_reg_test.sv
module vfp_status_reg_test;
    import vfp_status_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [127:0] wr_data;
    logic [127:0] rd_data;
    logic [11:0]  sp_set;
    logic [11:0]  dp_set;
    logic [3:0]   dz_set;
    logic         rm_wr_en;
    logic [1:0]   rm_wr_slice;
    logic [1:0]   rm_wr_val;
    logic [1:0]   rm_rd_slice;
    logic [1:0]   rm_rd_val;

    int checks   = 0;
    int failures = 0;
    logic [31:0] m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    vfp_status_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sp_set(sp_set), .dp_set(dp_set), .dz_set(dz_set),
        .rm_wr_en(rm_wr_en), .rm_wr_slice(rm_wr_slice), .rm_wr_val(rm_wr_val),
        .rm_rd_slice(rm_rd_slice), .rm_rd_val(rm_rd_val)
    );

    function automatic logic [31:0] impl_mask(int w);
        return (w == 1 || w == 2) ? 32'h0000_3F07 : 32'h0000_0F07;
    endfunction

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; sp_set = '0; dp_set = '0; dz_set = '0;
        rm_wr_en = 0; rm_wr_slice = '0; rm_wr_val = '0;
    endtask

    // expected next state from the requirements, then one clock
    task automatic tick();
        logic [31:0] nm [4];
        for (int w = 0; w < 4; w++)
            nm[w] = wr_en ? (wr_data[32*w +: 32] & impl_mask(w)) : m[w];
        if (rm_wr_en && rm_wr_slice < 2)
            nm[3][8 + 2*rm_wr_slice +: 2] = rm_wr_val;
        for (int n = 0; n < 4; n++)
            nm[n][2:0] = nm[n][2:0] | sp_set[3*n +: 3];
        for (int n = 0; n < 2; n++)
            nm[n+1][13:8] = nm[n+1][13:8] | dp_set[6*n +: 6];
        nm[0][11:8] = nm[0][11:8] | dz_set;
        if (rst)
            for (int w = 0; w < 4; w++) nm[w] = '0;
        @(posedge clk);
        #1;
        for (int w = 0; w < 4; w++) m[w] = nm[w];
        idle_inputs();
    endtask

    task automatic check128(string tag);
        logic [127:0] exp;
        exp = {m[3], m[2], m[1], m[0]};
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    task automatic check_rm(string tag);
        for (int rs = 0; rs < 4; rs++) begin
            logic [1:0] exp;
            rm_rd_slice = rs[1:0];
            #1;
            exp = (rs < 2) ? m[3][8 + 2*rs +: 2] : 2'b00;
            checks++;
            if (rm_rd_val !== exp) begin
                failures++;
                $display("FAIL %s slice=%0d rm_rd_val=%0d expected=%0d", tag, rs, rm_rd_val, exp);
            end
        end
    endtask

    task automatic clear_reg();
        wr_en = 1; wr_data = '0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++) m[w] = '0;
        idle_inputs();
        rm_rd_slice = '0;
        rst = 1;
        #1;
        tick();
        tick();
        rst = 0;
        check128("R1 reset state");
        check_rm("R1 R10 reset rounding");

        // R1: reset discards a same-cycle write
        wr_en = 1; wr_data = '1;
        tick();
        rst = 1; wr_en = 1; wr_data = '1; sp_set = '1;
        tick();
        rst = 0;
        check128("R1 reset over write");

        // R2 R3: masked full writes, several patterns
        wr_en = 1; wr_data = '1;
        tick();
        check128("R2 all ones");
        for (int k = 0; k < 12; k++) begin
            for (int w = 0; w < 4; w++)
                wr_data[32*w +: 32] = 32'(k * 32'h9E37_79B9 + w * 32'h7F4A_7C15 + 32'h1234_5678);
            wr_en = 1;
            tick();
            check128("R2 R3 scrambled write");
            check_rm("R10 after write");
        end

        // R4: single-precision sweep
        for (int s = 0; s < 4; s++)
            for (int p = 1; p < 8; p++) begin
                clear_reg();
                sp_set[3*s +: 3] = p[2:0];
                tick();
                check128("R4 single flags");
            end

        // R5: double-precision sweep
        for (int s = 0; s < 2; s++)
            for (int p = 1; p < 64; p++) begin
                clear_reg();
                dp_set[6*s +: 6] = p[5:0];
                tick();
                check128("R5 double flags");
            end

        // R6: divide-by-zero sweep
        for (int p = 1; p < 16; p++) begin
            clear_reg();
            dz_set = p[3:0];
            tick();
            check128("R6 divide by zero");
        end

        // R7: sticky accumulation and hold
        clear_reg();
        sp_set[8] = 1'b1;
        tick();
        sp_set[6] = 1'b1; dp_set[11] = 1'b1; dz_set[3] = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) tick();
        check128("R7 sticky hold");
        sp_set[8] = 1'b1;
        tick();
        check128("R7 repeat strobe");
        clear_reg();
        check128("R7 write clears");

        // R8: write and strobes in the same cycle
        for (int k = 0; k < 4; k++) begin
            wr_en = 1;
            for (int w = 0; w < 4; w++)
                wr_data[32*w +: 32] = 32'(k * 32'h2545_F491 + w * 32'h0000_0A51);
            sp_set = 12'(k * 12'h5A3 + 1);
            dp_set = 12'(k * 12'h3C7 + 3);
            dz_set = 4'(k + 5);
            tick();
            check128("R8 write then set");
        end

        // R9 R10: rounding writes in range
        clear_reg();
        for (int s = 0; s < 2; s++)
            for (int v = 0; v < 4; v++) begin
                rm_wr_en = 1; rm_wr_slice = s[1:0]; rm_wr_val = v[1:0];
                tick();
                check128("R9 rounding write");
                check_rm("R10 rounding read");
            end
        // R9: rounding write overrides a same-cycle full write
        wr_en = 1; wr_data = '1;
        rm_wr_en = 1; rm_wr_slice = 2'd1; rm_wr_val = 2'd0;
        tick();
        check128("R9 rounding after write");
        check_rm("R9 R10 field after write");

        // R11: out-of-range rounding index
        wr_en = 1; wr_data = {32'h0000_0A07, 96'h0};
        tick();
        for (int s = 2; s < 4; s++)
            for (int v = 0; v < 4; v++) begin
                rm_wr_en = 1; rm_wr_slice = s[1:0]; rm_wr_val = v[1:0];
                tick();
                check128("R11 ignored write");
                check_rm("R11 read out of range");
            end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule